// File: doc/BRIEF.md
# Serial Display-Memory Host Port

This block is the host-facing side of a segment display controller. A host reaches a 64-column by 16-bit display memory (1024 bits) and a small set of control flags over four wires: an active-low select, a write strobe, a read strobe and one data line. The data line is modelled as separate input, output and output-enable signals. All four host lines are synchronised into the core clock, so every strobe level must last several core clock periods.

A transfer opens when select falls. It starts with a 3-bit mode identifier. Memory accesses then carry a 6-bit column address, followed by 16-bit words, most significant bit first. The port supports writes, reads and read-modify-write, and the column address advances after every word. Command transfers carry a stream of 9-bit control words, which set the oscillator, display, timer, tone and power-down flags. Raising select at any point abandons the transfer. A separate combinational scan port lets the display driver read any column at any time.

Top module: `lcd3w_port`

## Requirements
- R1: While `cs_n` is high, strobes have no effect and the serial state returns to the start of a transfer. Raising `cs_n` in the middle of a word discards that partial word, so the memory column keeps its old value.
- R2: The first three bits after `cs_n` falls are captured on `wr_n` rising edges, MSB first. They select the transfer type: 3'b100 = command, 3'b101 = write, 3'b110 = read, 3'b111 = read-modify-write. Any other value makes the rest of the transfer have no effect.
- R3: In a write transfer, a 6-bit address and then 16-bit words are captured, MSB first, on `wr_n` rising edges. Each word is stored when its 16th bit arrives.
- R4: In a read transfer, each `rd_n` rising edge places the next bit of the addressed word, MSB first, on `data_out`. The bit holds until the next `rd_n` rising edge.
- R5: The column address increments after every completed word and wraps from 63 to 0.
- R6: In read-modify-write, each column is first read with 16 `rd_n` edges and then overwritten with 16 `wr_n` bits. Only then does the address advance.
- R7: `data_oe` is high only in the data phase of a read transfer and in the read half of each read-modify-write column. It is low in every other state.
- R8: A command transfer accepts any number of 9-bit words, MSB first. The encodings are: 9'h010 oscillator off, 9'h011 oscillator on, 9'h020 display off, 9'h021 display on, 9'h030 timer disable, 9'h031 timer enable, 9'h032 timer clear (a one-cycle `tmr_clr` pulse), 9'h040 low tone, 9'h041 high tone. Other words are ignored.
- R9: The word 9'h050 sets `pdown` and clears `osc_on` and `lcd_on`. The oscillator-on word clears `pdown`.
- R10: After reset, all control outputs and `data_oe` are 0, and every memory column reads 0.
- R11: `scan_data` always equals the stored word of column `scan_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Host select, active low |
| wr_n | input | 1 | Host write strobe, data taken on rising edge |
| rd_n | input | 1 | Host read strobe, data launched on rising edge |
| data_in | input | 1 | Serial data from host |
| data_out | output | 1 | Serial data to host |
| data_oe | output | 1 | Drive enable for the data line |
| scan_addr | input | 6 | Display scan column select |
| scan_data | output | 16 | Word stored at `scan_addr` |
| osc_on | output | 1 | Oscillator enable flag |
| lcd_on | output | 1 | Display enable flag |
| tmr_en | output | 1 | Timer enable flag |
| tmr_clr | output | 1 | One-cycle timer clear pulse |
| tone_hi | output | 1 | Tone select, 1 = high tone |
| pdown | output | 1 | Power-down flag |

## Verification
The assertions assume that each host line holds each level for more than three core clock periods. They also assume that `cs_n` is high only while both strobes are idle, and that `data_in` is stable around every `wr_n` rising edge. Under these assumptions, every synchronised edge is seen exactly once. The stimulus tasks hold every strobe level for six clocks, set `data_in` while `wr_n` is low, and leave at least four clocks of margin on both sides of each select change. Checks take place on falling clock edges, well after the synchroniser latency.

// File: rtl/lcd3w_pkg.sv
package lcd3w_pkg;

    localparam int ID_LEN  = 3;
    localparam int CMD_LEN = 9;

    localparam logic [ID_LEN-1:0] ID_CMD = 3'b100;
    localparam logic [ID_LEN-1:0] ID_WR  = 3'b101;
    localparam logic [ID_LEN-1:0] ID_RD  = 3'b110;
    localparam logic [ID_LEN-1:0] ID_RMW = 3'b111;

    localparam logic [CMD_LEN-1:0] OP_OSC_OFF = 9'h010;
    localparam logic [CMD_LEN-1:0] OP_OSC_ON  = 9'h011;
    localparam logic [CMD_LEN-1:0] OP_LCD_OFF = 9'h020;
    localparam logic [CMD_LEN-1:0] OP_LCD_ON  = 9'h021;
    localparam logic [CMD_LEN-1:0] OP_TMR_DIS = 9'h030;
    localparam logic [CMD_LEN-1:0] OP_TMR_EN  = 9'h031;
    localparam logic [CMD_LEN-1:0] OP_TMR_CLR = 9'h032;
    localparam logic [CMD_LEN-1:0] OP_TONE_LO = 9'h040;
    localparam logic [CMD_LEN-1:0] OP_TONE_HI = 9'h041;
    localparam logic [CMD_LEN-1:0] OP_PDOWN   = 9'h050;

    typedef enum logic [2:0] {
        PH_ID, PH_ADDR, PH_DATA, PH_CMD, PH_HALT
    } phase_e;

    typedef enum logic [1:0] {
        MD_WRITE, MD_READ, MD_RMW
    } mode_e;

endpackage

// File: rtl/lcd3w_sync.sv
module lcd3w_sync #(
    parameter int           N       = 4,
    parameter int           STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] lvl
);

    logic [N-1:0] stage_d [STAGES];
    logic [N-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = raw;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= RST_VAL;
            end
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= stage_d[s];
            end
        end
    end

    assign lvl = stage_q[STAGES-1];

endmodule

// File: rtl/lcd3w_mem.sv
module lcd3w_mem #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [WORD_W-1:0] rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [WORD_W-1:0] rdata_b
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] row_d [DEPTH];
    logic [WORD_W-1:0] row_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_row
        always_comb begin
            row_d[i] = row_q[i];
            if (we && (waddr == ADDR_W'(i))) begin
                row_d[i] = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                row_q[i] <= '0;
            end else begin
                row_q[i] <= row_d[i];
            end
        end
    end

    assign rdata_a = row_q[raddr_a];
    assign rdata_b = row_q[raddr_b];

    // R11: a written row shows the new word on the scan port next cycle
    a_r11_scan_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == raddr_b) |=> (rdata_b == $past(wdata) || raddr_b != $past(raddr_b)));

endmodule

// File: rtl/lcd3w_frame.sv
module lcd3w_frame
    import lcd3w_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_hi,
    input  logic               wr_lvl,
    input  logic               rd_lvl,
    input  logic               din,
    output logic [ADDR_W-1:0]  raddr,
    input  logic [WORD_W-1:0]  rword,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  waddr,
    output logic [WORD_W-1:0]  wdata,
    output logic               cmd_valid,
    output logic [CMD_LEN-1:0] cmd_word,
    output logic               data_out,
    output logic               data_oe
);

    localparam int L1     = (WORD_W > CMD_LEN) ? WORD_W : CMD_LEN;
    localparam int MAXLEN = (L1 > ADDR_W) ? L1 : ADDR_W;
    localparam int CNT_W  = $clog2(MAXLEN);
    localparam int SH_W   = MAXLEN - 1;

    typedef struct packed {
        phase_e            phase;
        mode_e             mode;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [SH_W-1:0]   sh;
        logic              dout;
        logic              rmw_wr;
        logic              wr_prev;
        logic              rd_prev;
    } st_t;

    st_t st_d, st_q;

    logic              wr_rise, rd_rise;
    logic              wr_side, rd_side;
    logic [MAXLEN-1:0] shifted;
    logic [CNT_W-1:0]  bit_idx;

    assign wr_rise = wr_lvl & ~st_q.wr_prev;
    assign rd_rise = rd_lvl & ~st_q.rd_prev;
    assign shifted = {st_q.sh, din};
    assign bit_idx = CNT_W'(WORD_W - 1) - st_q.cnt;

    assign wr_side = (st_q.phase == PH_DATA) &&
                     ((st_q.mode == MD_WRITE) || (st_q.mode == MD_RMW && st_q.rmw_wr));
    assign rd_side = (st_q.phase == PH_DATA) &&
                     ((st_q.mode == MD_READ) || (st_q.mode == MD_RMW && !st_q.rmw_wr));

    always_comb begin
        st_d      = st_q;
        mem_we    = 1'b0;
        cmd_valid = 1'b0;

        st_d.wr_prev = wr_lvl;
        st_d.rd_prev = rd_lvl;

        if (cs_hi) begin
            st_d.phase  = PH_ID;
            st_d.mode   = MD_WRITE;
            st_d.cnt    = '0;
            st_d.addr   = '0;
            st_d.sh     = '0;
            st_d.dout   = 1'b0;
            st_d.rmw_wr = 1'b0;
        end else begin
            unique case (st_q.phase)
                PH_ID: begin
                    if (wr_rise) begin
                        st_d.sh  = shifted[SH_W-1:0];
                        st_d.cnt = st_q.cnt + 1'b1;
                        if (st_q.cnt == CNT_W'(ID_LEN - 1)) begin
                            st_d.cnt = '0;
                            unique case (shifted[ID_LEN-1:0])
                                ID_CMD: st_d.phase = PH_CMD;
                                ID_WR: begin
                                    st_d.phase = PH_ADDR;
                                    st_d.mode  = MD_WRITE;
                                end
                                ID_RD: begin
                                    st_d.phase = PH_ADDR;
                                    st_d.mode  = MD_READ;
                                end
                                ID_RMW: begin
                                    st_d.phase = PH_ADDR;
                                    st_d.mode  = MD_RMW;
                                end
                                default: st_d.phase = PH_HALT;
                            endcase
                        end
                    end
                end

                PH_ADDR: begin
                    if (wr_rise) begin
                        st_d.sh  = shifted[SH_W-1:0];
                        st_d.cnt = st_q.cnt + 1'b1;
                        if (st_q.cnt == CNT_W'(ADDR_W - 1)) begin
                            st_d.cnt    = '0;
                            st_d.addr   = shifted[ADDR_W-1:0];
                            st_d.phase  = PH_DATA;
                            st_d.rmw_wr = 1'b0;
                        end
                    end
                end

                PH_DATA: begin
                    if (wr_side && wr_rise) begin
                        st_d.sh  = shifted[SH_W-1:0];
                        st_d.cnt = st_q.cnt + 1'b1;
                        if (st_q.cnt == CNT_W'(WORD_W - 1)) begin
                            mem_we      = 1'b1;
                            st_d.cnt    = '0;
                            st_d.addr   = st_q.addr + 1'b1;
                            st_d.rmw_wr = 1'b0;
                        end
                    end else if (rd_side && rd_rise) begin
                        st_d.dout = rword[bit_idx];
                        st_d.cnt  = st_q.cnt + 1'b1;
                        if (st_q.cnt == CNT_W'(WORD_W - 1)) begin
                            st_d.cnt = '0;
                            if (st_q.mode == MD_READ) begin
                                st_d.addr = st_q.addr + 1'b1;
                            end else begin
                                st_d.rmw_wr = 1'b1;
                            end
                        end
                    end
                end

                PH_CMD: begin
                    if (wr_rise) begin
                        st_d.sh  = shifted[SH_W-1:0];
                        st_d.cnt = st_q.cnt + 1'b1;
                        if (st_q.cnt == CNT_W'(CMD_LEN - 1)) begin
                            cmd_valid = 1'b1;
                            st_d.cnt  = '0;
                        end
                    end
                end

                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.phase   <= PH_ID;
            st_q.mode    <= MD_WRITE;
            st_q.wr_prev <= 1'b1;
            st_q.rd_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign raddr    = st_q.addr;
    assign waddr    = st_q.addr;
    assign wdata    = shifted[WORD_W-1:0];
    assign cmd_word = shifted[CMD_LEN-1:0];
    assign data_out = st_q.dout;
    assign data_oe  = rd_side;

    // R1: a high select leaves the port undriven on the next cycle
    a_r1_cs_releases_line: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> !data_oe);

    // R3: memory is only written on a write strobe edge
    a_r3_we_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wr_rise);

    // R4: the output bit only moves on a read strobe edge or a select abort
    a_r4_dout_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_rise && !cs_hi) |=> $stable(data_out));

    // R7: no memory write while the port drives the line
    a_r7_no_write_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !data_oe);

endmodule

// File: rtl/lcd3w_cmd.sv
module lcd3w_cmd
    import lcd3w_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [CMD_LEN-1:0] cmd_word,
    output logic               osc_on,
    output logic               lcd_on,
    output logic               tmr_en,
    output logic               tmr_clr,
    output logic               tone_hi,
    output logic               pdown
);

    typedef struct packed {
        logic osc;
        logic lcd;
        logic tmr;
        logic clr;
        logic tone;
        logic pd;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.clr = 1'b0;
        if (cmd_valid) begin
            case (cmd_word)
                OP_OSC_OFF: ctl_d.osc = 1'b0;
                OP_OSC_ON: begin
                    ctl_d.osc = 1'b1;
                    ctl_d.pd  = 1'b0;
                end
                OP_LCD_OFF: ctl_d.lcd  = 1'b0;
                OP_LCD_ON:  ctl_d.lcd  = 1'b1;
                OP_TMR_DIS: ctl_d.tmr  = 1'b0;
                OP_TMR_EN:  ctl_d.tmr  = 1'b1;
                OP_TMR_CLR: ctl_d.clr  = 1'b1;
                OP_TONE_LO: ctl_d.tone = 1'b0;
                OP_TONE_HI: ctl_d.tone = 1'b1;
                OP_PDOWN: begin
                    ctl_d.pd  = 1'b1;
                    ctl_d.osc = 1'b0;
                    ctl_d.lcd = 1'b0;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign osc_on  = ctl_q.osc;
    assign lcd_on  = ctl_q.lcd;
    assign tmr_en  = ctl_q.tmr;
    assign tmr_clr = ctl_q.clr;
    assign tone_hi = ctl_q.tone;
    assign pdown   = ctl_q.pd;

    // R9: power-down and a running oscillator never coexist
    a_r9_pdown_stops_osc: assert property (@(posedge clk) disable iff (!rst_n)
        pdown |-> !osc_on);

    // R8: the timer clear is a single-cycle pulse
    a_r8_clr_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_clr |=> !tmr_clr);

endmodule

// File: rtl/lcd3w_port.sv
module lcd3w_port
    import lcd3w_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              data_in,
    output logic              data_out,
    output logic              data_oe,
    input  logic [ADDR_W-1:0] scan_addr,
    output logic [WORD_W-1:0] scan_data,
    output logic              osc_on,
    output logic              lcd_on,
    output logic              tmr_en,
    output logic              tmr_clr,
    output logic              tone_hi,
    output logic              pdown
);

    localparam int NSYNC = 4;

    logic [NSYNC-1:0]   sync_lvl;
    logic [ADDR_W-1:0]  raddr, waddr;
    logic [WORD_W-1:0]  rword, wdata;
    logic               mem_we, cmd_valid;
    logic [CMD_LEN-1:0] cmd_word;

    lcd3w_sync #(
        .N       (NSYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b0111)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({data_in, rd_n, wr_n, cs_n}),
        .lvl   (sync_lvl)
    );

    lcd3w_frame #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_hi     (sync_lvl[0]),
        .wr_lvl    (sync_lvl[1]),
        .rd_lvl    (sync_lvl[2]),
        .din       (sync_lvl[3]),
        .raddr     (raddr),
        .rword     (rword),
        .mem_we    (mem_we),
        .waddr     (waddr),
        .wdata     (wdata),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .data_out  (data_out),
        .data_oe   (data_oe)
    );

    lcd3w_mem #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (mem_we),
        .waddr   (waddr),
        .wdata   (wdata),
        .raddr_a (raddr),
        .rdata_a (rword),
        .raddr_b (scan_addr),
        .rdata_b (scan_data)
    );

    lcd3w_cmd u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .osc_on    (osc_on),
        .lcd_on    (lcd_on),
        .tmr_en    (tmr_en),
        .tmr_clr   (tmr_clr),
        .tone_hi   (tone_hi),
        .pdown     (pdown)
    );

endmodule

// File: tb/tb_lcd3w_port.sv
module tb_lcd3w_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        data_in = 1'b0;
    logic [5:0]  scan_addr = '0;
    logic        data_out, data_oe;
    logic [15:0] scan_data;
    logic        osc_on, lcd_on, tmr_en, tmr_clr, tone_hi, pdown;

    lcd3w_port dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
        .scan_addr(scan_addr), .scan_data(scan_data),
        .osc_on(osc_on), .lcd_on(lcd_on), .tmr_en(tmr_en), .tmr_clr(tmr_clr),
        .tone_hi(tone_hi), .pdown(pdown)
    );

    always #10 clk = ~clk;

    int          checks = 0;
    int          fails = 0;
    int          clr_pulses = 0;
    int          nbits = 0;
    bit          done = 1'b0;
    logic [15:0] model [64];
    logic [15:0] acc = '0;
    logic [15:0] exp_q [$];
    string       tag_q [$];
    event        rd_smp;

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_bit(input logic b);
        data_in = b;
        wr_n = 1'b0;
        clks(6);
        wr_n = 1'b1;
        clks(6);
    endtask

    task automatic rd_bit();
        rd_n = 1'b0;
        clks(6);
        rd_n = 1'b1;
        clks(6);
        -> rd_smp;
        clks(1);
    endtask

    task automatic send(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) wr_bit(v[i]);
    endtask

    task automatic open_x();
        cs_n = 1'b0;
        clks(4);
    endtask

    task automatic close_x();
        clks(4);
        cs_n = 1'b1;
        clks(6);
    endtask

    task automatic wframe(input logic [5:0] a, input logic [15:0] ws [$]);
        logic [5:0] p = a;
        open_x();
        send(16'b101, 3);
        send(16'(a), 6);
        foreach (ws[i]) begin
            send(ws[i], 16);
            model[p] = ws[i];
            p = p + 6'd1;
        end
        close_x();
    endtask

    task automatic rframe(input logic [5:0] a, input int n, input string tag);
        logic [5:0] p = a;
        open_x();
        send(16'b110, 3);
        send(16'(a), 6);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(model[p]);
            tag_q.push_back(tag);
            for (int b = 0; b < 16; b++) rd_bit();
            p = p + 6'd1;
        end
        close_x();
    endtask

    task automatic rmwframe(input logic [5:0] a, input logic [15:0] ws [$], input string tag);
        logic [5:0] p = a;
        open_x();
        send(16'b111, 3);
        send(16'(a), 6);
        foreach (ws[i]) begin
            exp_q.push_back(model[p]);
            tag_q.push_back(tag);
            for (int b = 0; b < 16; b++) rd_bit();
            send(ws[i], 16);
            model[p] = ws[i];
            p = p + 6'd1;
        end
        close_x();
    endtask

    task automatic cframe(input logic [8:0] ops [$]);
        open_x();
        send(16'b100, 3);
        foreach (ops[i]) send(16'(ops[i]), 9);
        close_x();
    endtask

    task automatic scan_chk(input logic [5:0] a, input string tag);
        scan_addr = a;
        clks(1);
        chk(tag, 32'(scan_data), 32'(model[a]));
    endtask

    function automatic logic [31:0] ctl();
        return 32'({osc_on, lcd_on, tmr_en, tone_hi, pdown});
    endfunction

    // monitor: assembles read bits and compares against the scoreboard
    always @(rd_smp) begin
        acc = {acc[14:0], data_out};
        nbits++;
        if (nbits == 16) begin
            nbits = 0;
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R4 actual=%0h expected=none", acc);
            end else begin
                chk(tag_q.pop_front(), 32'(acc), 32'(exp_q.pop_front()));
            end
        end
    end

    always @(negedge clk) if (tmr_clr) clr_pulses++;

    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) model[i] = '0;
        clks(5);
        // R10: reset state
        chk("R10", ctl(), 0);
        chk("R10", 32'(data_oe), 0);
        chk("R10", 32'(tmr_clr), 0);
        scan_chk(6'd33, "R10");
        rst_n = 1'b1;
        clks(4);

        // R3 / R11: write two words and observe the scan port
        wframe(6'd5, '{16'hA5C3, 16'h1234});
        scan_chk(6'd5, "R3");
        scan_chk(6'd6, "R11");

        // R5: write across the top of the address range
        wframe(6'd62, '{16'h0F0F, 16'hBEEF, 16'h7001});
        scan_chk(6'd63, "R5");
        scan_chk(6'd0, "R5");

        // R4 / R5: read back, including the wrap
        rframe(6'd62, 3, "R5");
        rframe(6'd5, 2, "R4");

        // R7: enable in read data phase, not in write data phase
        open_x();
        send(16'b110, 3);
        send(16'd5, 6);
        clks(2);
        chk("R7", 32'(data_oe), 1);
        close_x();
        chk("R7", 32'(data_oe), 0);
        open_x();
        send(16'b101, 3);
        send(16'd7, 6);
        chk("R7", 32'(data_oe), 0);
        send(16'h4444, 16);
        model[7] = 16'h4444;
        close_x();
        scan_chk(6'd7, "R3");

        // R7 / R6: enable drops in the write half of a read-modify-write
        open_x();
        send(16'b111, 3);
        send(16'd7, 6);
        chk("R7", 32'(data_oe), 1);
        exp_q.push_back(model[7]);
        tag_q.push_back("R6");
        for (int b = 0; b < 16; b++) rd_bit();
        chk("R7", 32'(data_oe), 0);
        send(16'hC0DE, 16);
        model[7] = 16'hC0DE;
        close_x();
        scan_chk(6'd7, "R6");

        // R6: two columns read then overwritten
        rmwframe(6'd5, '{16'h5555, 16'h6666}, "R6");
        scan_chk(6'd5, "R6");
        scan_chk(6'd6, "R6");
        rframe(6'd5, 2, "R6");

        // R1: abort mid-word, then strobes while deselected
        open_x();
        send(16'b101, 3);
        send(16'd20, 6);
        send(16'hFF, 8);
        close_x();
        scan_chk(6'd20, "R1");
        for (int i = 0; i < 16; i++) wr_bit(1'b1);
        scan_chk(6'd20, "R1");
        wframe(6'd20, '{16'h9ABC});
        scan_chk(6'd20, "R1");

        // R2: unknown identifiers make the transfer inert
        open_x();
        send(16'b011, 3);
        send(16'd20, 6);
        send(16'h0000, 16);
        close_x();
        scan_chk(6'd20, "R2");
        open_x();
        send(16'b001, 3);
        send(16'h011, 9);
        close_x();
        chk("R2", ctl(), 0);

        // R8: several command words in one transfer
        cframe('{9'h011, 9'h021, 9'h031, 9'h041, 9'h1FF});
        chk("R8", ctl(), 32'b11110);
        cframe('{9'h032});
        chk("R8", 32'(clr_pulses), 1);
        cframe('{9'h040, 9'h030, 9'h020});
        chk("R8", ctl(), 32'b10000);

        // R9: power-down and wake
        cframe('{9'h021, 9'h050});
        chk("R9", ctl(), 32'b00001);
        cframe('{9'h011});
        chk("R9", ctl(), 32'b10000);

        chk("R4", 32'(exp_q.size()), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule